// File: doc/BRIEF.md
# Key Matrix Scanner with Shared Source Lines

This block reads a single-column key matrix whose six source lines are the first six segment pins of a multiplexed display driver. The display grid scanner marks a key-scan slot at the end of every display frame. During that slot the block takes control of the shared pins through a mux select. It raises the source lines high one at a time and samples the single return line, which has a pull-down, while each source is active. An open key therefore reads 0 and a pressed key reads 1.

A full scan needs two display frames. The first frame's slot scans sources 1 to 3 and the second frame's slot scans sources 4 to 6. The samples collect in a shadow register. When a scan completes, the result moves to a staging register. From there it is copied in one cycle into the readable key register, which is packed into three bytes for the serial interface. The copy waits while the serial interface signals that a read is in progress, so a read never sees two scans mixed together.

Top module: `key_matrix_scan`

## Requirements
- R1: After reset, or while reset is held, every source line, the mux select and all key data bits are 0.
- R2: One cycle after the slot marker is first seen high, the mux select goes high. The sources are then driven one-hot in order, each for SUB_CYC cycles. In a frame with even parity (the first after reset) the order is source 1, 2, 3. In a frame with odd parity it is source 4, 5, 6. After the third source, no source is high until the slot ends.
- R3: One cycle after the slot marker is seen low, the mux select and all source lines are 0, and they stay at 0 while the marker is low.
- R4: The return line is sampled once per source, SUB_CYC-2 cycles after that source goes high. A sampled 1 means the key is pressed. Return-line values in all other cycles have no effect on the key data.
- R5: The key data changes only after the slot of an odd-parity frame, when a two-frame scan is complete. It is updated two clock edges after the marker is seen low. The end of an even-parity frame leaves the key data unchanged.
- R6: Packing uses key_data_o[7:0] as byte 0, [15:8] as byte 1 and [23:16] as byte 2. Byte 0 holds source 1 at bit 1 and source 2 at bit 4. Byte 1 holds sources 3 and 4 at the same two positions, and byte 2 holds sources 5 and 6. Every other bit, bit 7 included, reads 0.
- R7: While rd_busy_i is high, key_data_o does not change. A completed scan that is waiting is copied on the first clock edge at which rd_busy_i is low.
- R8: If further scans complete while a read holds off the copy, the copy takes the most recent complete scan as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_slot_i | input | 1 | Key-scan slot marker from the grid scanner |
| key_ret_i | input | 1 | Raw return line (pull-down; 1 means pressed) |
| rd_busy_i | input | 1 | Serial read in progress; holds off the key register copy |
| ks_o | output | 6 | Source line drive values, bit 0 is source 1 |
| key_mux_o | output | 1 | Selects key sources onto the shared segment pins |
| key_data_o | output | 24 | Packed key bytes, byte 0 in bits 7:0 |

## Verification
The source and mux outputs are due one edge after the slot marker changes. Each source sample point falls SUB_CYC-2 cycles after its source rises. The key bytes are due two edges after the marker falls at the end of an odd-parity frame, or one edge after rd_busy_i drops when a copy is waiting. The bench drives the inputs and checks the outputs on falling clock edges, and it counts from these edges to pick the exact cycle for each check. The return line is driven by a model of the matrix that reads the live source outputs. In the noise test the bench inverts the return line in every cycle except the sample cycle.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  // source s lands in byte s/2, at bit 1 (even s) or bit 4 (odd s)
  function automatic int unsigned key_bit_pos(input int unsigned src);
    return (src / 2) * 8 + 1 + 3 * (src % 2);
  endfunction
endpackage

// File: rtl/kscan_seq.sv
module kscan_seq #(
  parameter int unsigned N_SRC     = 6,
  parameter int unsigned SUB_CYC   = 8,
  parameter int unsigned SAMPLE_AT = SUB_CYC - 2,
  localparam int unsigned SPF      = N_SRC / 2,
  localparam int unsigned SUBW     = $clog2(SUB_CYC),
  localparam int unsigned POSW     = $clog2(SPF + 1),
  localparam int unsigned IDXW     = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  output logic [N_SRC-1:0] ks_o,
  output logic             mux_o,
  output logic             smp_o,
  output logic [IDXW-1:0]  smp_idx_o,
  output logic             cyc_end_o
);
  logic            active_q, half_q;
  logic [SUBW-1:0] sub_q;
  logic [POSW-1:0] pos_q;
  logic            in_src;
  logic [IDXW-1:0] cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      sub_q    <= '0;
      pos_q    <= '0;
    end else if (slot_i) begin
      if (!active_q) begin
        active_q <= 1'b1;
        sub_q    <= '0;
        pos_q    <= '0;
      end else if (pos_q < POSW'(SPF)) begin
        if (sub_q == SUBW'(SUB_CYC - 1)) begin
          sub_q <= '0;
          pos_q <= pos_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end else begin
      active_q <= 1'b0;
      if (active_q) half_q <= ~half_q;
    end
  end

  assign in_src    = active_q && (pos_q < POSW'(SPF));
  assign cur_idx   = half_q ? IDXW'(pos_q) + IDXW'(SPF) : IDXW'(pos_q);
  assign smp_idx_o = cur_idx;
  assign smp_o     = in_src && slot_i && (sub_q == SUBW'(SAMPLE_AT));
  assign cyc_end_o = active_q && !slot_i && half_q;
  assign mux_o     = active_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign ks_o[i] = in_src && (cur_idx == IDXW'(i));
  end

  a_r2_src_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ks_o));
  a_r2_mux_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot_i) |=> mux_o);
  a_r3_mux_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> (!mux_o && ks_o == '0));
  a_r3_src_needs_mux: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ks_o != '0) |-> mux_o);
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture
  import kscan_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned N_BYTE = (N_SRC + 1) / 2,
  localparam int unsigned KEY_W  = 8 * N_BYTE,
  localparam int unsigned IDXW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [IDXW-1:0]  smp_idx_i,
  input  logic             ret_i,
  input  logic             cyc_end_i,
  input  logic             rd_busy_i,
  output logic [KEY_W-1:0] key_o
);
  logic [N_SRC-1:0] shadow_q, done_q, key_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      done_q   <= '0;
      key_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (smp_i) shadow_q[smp_idx_i] <= ret_i;
      if (cyc_end_i) begin
        done_q <= shadow_q;
        pend_q <= 1'b1;
      end else if (pend_q && !rd_busy_i) begin
        key_q  <= done_q;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    key_o = '0;
    for (int unsigned i = 0; i < N_SRC; i++) key_o[key_bit_pos(i)] = key_q[i];
  end

  a_r7_hold_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_i |=> $stable(key_o));
  a_r5_copy_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(key_q));
  a_r8_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !rd_busy_i && !cyc_end_i) |=> !pend_q);
endmodule

// File: rtl/key_matrix_scan.sv
module key_matrix_scan #(
  parameter int unsigned N_SRC   = 6,
  parameter int unsigned SUB_CYC = 8,
  localparam int unsigned N_BYTE = (N_SRC + 1) / 2,
  localparam int unsigned KEY_W  = 8 * N_BYTE,
  localparam int unsigned IDXW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_slot_i,
  input  logic             key_ret_i,
  input  logic             rd_busy_i,
  output logic [N_SRC-1:0] ks_o,
  output logic             key_mux_o,
  output logic [KEY_W-1:0] key_data_o
);
  logic            smp, cyc_end;
  logic [IDXW-1:0] smp_idx;

  kscan_seq #(.N_SRC(N_SRC), .SUB_CYC(SUB_CYC), .SAMPLE_AT(SUB_CYC - 2)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_i    (key_slot_i),
    .ks_o      (ks_o),
    .mux_o     (key_mux_o),
    .smp_o     (smp),
    .smp_idx_o (smp_idx),
    .cyc_end_o (cyc_end)
  );

  kscan_capture #(.N_SRC(N_SRC)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp),
    .smp_idx_i (smp_idx),
    .ret_i     (key_ret_i),
    .cyc_end_i (cyc_end),
    .rd_busy_i (rd_busy_i),
    .key_o     (key_data_o)
  );
endmodule

// File: tb/key_matrix_scan_tb_top.sv
module key_matrix_scan_tb_top;
  localparam int S = 8;
  localparam int NV = 9;
  // {press[5:0], expected key bytes}
  localparam logic [29:0] VEC [NV] = '{
    {6'b000001, 24'h000002}, {6'b000010, 24'h000010}, {6'b000100, 24'h000200},
    {6'b001000, 24'h001000}, {6'b010000, 24'h020000}, {6'b100000, 24'h100000},
    {6'b111111, 24'h121212}, {6'b101010, 24'h101010}, {6'b000000, 24'h000000}
  };

  logic clk = 0, rst_n = 0, slot = 0, ret = 0, busy = 0;
  logic [5:0]  ks;
  logic        mux;
  logic [23:0] key;
  int n_chk = 0, n_fail = 0, half = 0;

  always #5 clk = ~clk;

  key_matrix_scan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_slot_i(slot), .key_ret_i(ret),
    .rd_busy_i(busy), .ks_o(ks), .key_mux_o(mux), .key_data_o(key)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one display frame with its key slot; starts and ends on a falling edge
  task automatic run_frame(input logic [5:0] press, input bit noise);
    int bad = 0, idle_bad = 0;
    logic model;
    slot = 1;
    ret = noise;
    for (int c = 0; c < 3 * S + 4; c++) begin
      logic [5:0] exp_ks;
      @(negedge clk);
      exp_ks = (c / S < 3) ? 6'(1 << (half * 3 + c / S)) : 6'd0;
      if (ks !== exp_ks || mux !== 1'b1) bad++;
      model = |(ks & press);
      ret = noise ? ((c % S == S - 2) ? model : ~model) : model;
    end
    chk("R2 source sequence errors", bad, 0);
    slot = 0;
    ret = noise;
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      if (ks !== 6'd0 || mux !== 1'b0) idle_bad++;
    end
    chk("R3 idle outside slot", idle_bad, 0);
    half ^= 1;
  endtask

  task automatic run_scan(input logic [5:0] press, input logic [23:0] exp, input bit noise);
    logic [23:0] prev;
    prev = key;
    run_frame(press, noise);
    chk("R5 no update after first frame", key, prev);
    run_frame(press, noise);
    if (!busy) chk("R6 R4 packed key bytes", key, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sources", ks, 0);
    chk("R1 reset mux", mux, 0);
    chk("R1 reset key", key, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_scan(VEC[v][29:24], VEC[v][23:0], 1'b0);

    // R5: exact latency, two edges after marker low
    begin
      logic [23:0] k1;
      run_frame(6'b000011, 1'b0);
      slot = 1;
      for (int c = 0; c < 3 * S + 4; c++) begin
        @(negedge clk);
        ret = |(ks & 6'b000011);
      end
      slot = 0;
      ret = 0;
      @(negedge clk);
      k1 = key;
      chk("R5 one edge after end", k1, 24'h000000);
      @(negedge clk);
      chk("R5 two edges after end", key, 24'h000012);
      half ^= 1;
      repeat (4) @(negedge clk);
    end

    // R4: return toggles outside sample points are ignored
    run_scan(6'b010101, 24'h020202, 1'b1);

    // R7: busy holds, copy on first edge with busy low
    busy = 1;
    run_scan(6'b100100, 24'h100200, 1'b0);
    chk("R7 held during read", key, 24'h020202);
    busy = 0;
    @(negedge clk);
    chk("R7 copy after release", key, 24'h100200);

    // R8: newest full scan wins
    busy = 1;
    run_scan(6'b000001, 24'h000002, 1'b0);
    run_scan(6'b110000, 24'h120000, 1'b0);
    chk("R8 still held", key, 24'h100200);
    busy = 0;
    @(negedge clk);
    chk("R8 newest scan copied", key, 24'h120000);

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears key", key, 0);
    chk("R1 reset clears mux", mux, 0);
    rst_n = 1;
    half = 0;
    @(negedge clk);
    run_scan(6'b001001, 24'h001002, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule